// File: doc/BRIEF.md
# Palette DAC Hidden Register Access Port

This block is the host-facing register front end of a palette DAC. The host sees only two byte-wide ports on a small bus: a write-address port and a pixel-mask port, chosen by one select line and driven by separate read and write strobes. In normal use, reads and writes of the mask port reach the pixel mask register.

Extra registers are reached without any added address lines. The block counts consecutive reads of the mask port. After four such reads, the next mask-port access lands on a hidden command register. One bit of that register opens a bank of extended registers. Once the bank is open, five reads followed by two writes load a 16-bit index, low byte first. Every later mask-port access then reads or writes the indexed register and steps the index. A write to the address port returns the port to its plain behaviour. The bank holds a primary pixel mode, a secondary pixel mode, a pipeline timing byte and a two-byte clock synthesiser word, all as plain storage.

Top module: `ramdac_port`

## Requirements
- R1: After reset, the pixel mask holds 0xFF. The command register, every extended register and the index all hold 0x00.
- R2: A write to the address port (port_sel = 0) clears the consecutive-read count. The first mask-port read (port_sel = 1) after it returns the pixel mask.
- R3: After exactly four consecutive mask-port reads, the next mask-port access reaches the command register. A read there returns it and a write there loads it. A write there also clears the count.
- R4: The read count saturates. A sixth or later consecutive mask-port read returns the pixel mask, and a mask-port write after six or more reads loads the pixel mask.
- R5: When command bit 4 (value 0x10) is set, a mask-port write after exactly five consecutive reads loads the index low byte. The next mask-port write loads the index high byte.
- R6: Once both index bytes are loaded, each mask-port read or write accesses the register at the index and then adds one to the index. The index wraps from 0xFFFF to 0x0000. These accesses never change the pixel mask.
- R7: The extended registers sit at these index values: 0x0003 primary pixel mode, 0x0004 secondary pixel mode, 0x0005 pipeline timing, 0x0024 clock word low byte, 0x0025 clock word high byte. All 16 index bits are decoded. Any other index value reads 0x00 and ignores writes.
- R8: A write to the address port ends indexed access. Later mask-port accesses reach the pixel mask again, and the extended registers keep their contents.
- R9: When command bit 4 is clear, mask-port writes after five consecutive reads are ordinary pixel-mask writes.
- R10: A mask-port write that reaches the pixel mask clears the read count. Four new reads are then needed to reach the command register.
- R11: bus_rdata is 0x00 whenever no mask-port read is under way. An address-port read returns 0x00 and neither clears nor advances the read count.
- R12: When bus_wr and bus_rd are both high in the same cycle, the cycle is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the address port, 1 selects the mask port |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_rd | input | 1 | Read strobe, one access per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |

## Verification
The unlock counter is driven with runs of exactly four, five and more than six reads. These runs separate command access, index loading and saturation. The same runs are also cut short by a mask write or an address-port read, which shows whether the count is cleared or left untouched. Indexed traffic is run with the enable bit both set and clear. It writes and reads every implemented register, probes an unused index and one that differs only in its high byte, and starts a read burst at 0xFFFF to expose the wrap. Each session is then closed through the address port, and the pixel mask is read to confirm that it was not disturbed.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 2 * DATA_W;
  localparam int XEN_BIT = 4;
  localparam int NXREG   = 5;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_MASK,
    TGT_CMD,
    TGT_IDX_LO,
    TGT_IDX_HI,
    TGT_XREG
  } tgt_e;

  typedef enum logic [1:0] {
    SEQ_PLAIN,
    SEQ_IDX_HI,
    SEQ_XDATA
  } seq_e;

  localparam logic [IDX_W-1:0] XREG_ADDR [NXREG] = '{
    16'h0003, 16'h0004, 16'h0005, 16'h0024, 16'h0025
  };
endpackage

// File: rtl/ramdac_seq.sv
module ramdac_seq
  import ramdac_pkg::*;
#(
  parameter int CMD_AT = 4,
  parameter int IDX_AT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              mask_wr,
  input  logic              mask_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xen,
  output tgt_e              tgt,
  output seq_e              mode,
  output logic [IDX_W-1:0]  index
);
  localparam int CNT_SAT = IDX_AT + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);
  localparam logic [CNT_W-1:0] CMD_CNT = CMD_AT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] IDX_CNT = IDX_AT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] SAT_CNT = CNT_SAT[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q, cnt_d;
  seq_e             mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cnt_en, mode_en, idx_en;

  always_comb begin
    tgt     = TGT_NONE;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    idx_d   = idx_q;
    cnt_en  = 1'b0;
    mode_en = 1'b0;
    idx_en  = 1'b0;
    if (addr_wr) begin
      cnt_d   = '0;
      mode_d  = SEQ_PLAIN;
      cnt_en  = 1'b1;
      mode_en = 1'b1;
    end else if (mask_wr) begin
      unique case (mode_q)
        SEQ_PLAIN: begin
          cnt_d  = '0;
          cnt_en = 1'b1;
          if (cnt_q == CMD_CNT) begin
            tgt = TGT_CMD;
          end else if (cnt_q == IDX_CNT && xen) begin
            tgt     = TGT_IDX_LO;
            idx_d   = {idx_q[IDX_W-1:DATA_W], wdata};
            idx_en  = 1'b1;
            mode_d  = SEQ_IDX_HI;
            mode_en = 1'b1;
          end else begin
            tgt = TGT_MASK;
          end
        end
        SEQ_IDX_HI: begin
          tgt     = TGT_IDX_HI;
          idx_d   = {wdata, idx_q[DATA_W-1:0]};
          idx_en  = 1'b1;
          mode_d  = SEQ_XDATA;
          mode_en = 1'b1;
        end
        default: begin
          tgt    = TGT_XREG;
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      endcase
    end else if (mask_rd) begin
      unique case (mode_q)
        SEQ_PLAIN: begin
          tgt    = (cnt_q == CMD_CNT) ? TGT_CMD : TGT_MASK;
          cnt_d  = (cnt_q == SAT_CNT) ? cnt_q : cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
        SEQ_IDX_HI: begin
          tgt     = TGT_MASK;
          cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
          cnt_en  = 1'b1;
          mode_d  = SEQ_PLAIN;
          mode_en = 1'b1;
        end
        default: begin
          tgt    = TGT_XREG;
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= SEQ_PLAIN;
      idx_q  <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mode_en) mode_q <= mode_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign mode  = mode_q;
  assign index = idx_q;
endmodule

// File: rtl/ramdac_xbank.sv
module ramdac_xbank
  import ramdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] reg_q [NXREG];
  logic [NXREG-1:0]  hit;

  for (genvar g = 0; g < NXREG; g++) begin : g_reg
    assign hit[g] = (index == XREG_ADDR[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else if (we && hit[g]) reg_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NXREG; i++) begin
      if (hit[i]) rdata = rdata | reg_q[i];
    end
  end
endmodule

// File: rtl/ramdac_port.sv
module ramdac_port
  import ramdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              addr_wr, mask_wr, mask_rd;
  tgt_e              tgt;
  seq_e              seq_mode;
  logic [IDX_W-1:0]  index;
  logic [DATA_W-1:0] pmask_q, pmask_d, cmd_q, cmd_d, x_rdata;
  logic              pmask_en, cmd_en, x_we;

  assign addr_wr = bus_wr & ~port_sel;
  assign mask_wr = bus_wr & port_sel;
  assign mask_rd = bus_rd & ~bus_wr & port_sel;

  ramdac_seq #(.CMD_AT(4), .IDX_AT(5)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_wr (addr_wr),
    .mask_wr (mask_wr),
    .mask_rd (mask_rd),
    .wdata   (bus_wdata),
    .xen     (cmd_q[XEN_BIT]),
    .tgt     (tgt),
    .mode    (seq_mode),
    .index   (index)
  );

  assign x_we = mask_wr && (tgt == TGT_XREG);

  ramdac_xbank i_xbank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (x_we),
    .index (index),
    .wdata (bus_wdata),
    .rdata (x_rdata)
  );

  always_comb begin
    pmask_en = mask_wr && (tgt == TGT_MASK);
    cmd_en   = mask_wr && (tgt == TGT_CMD);
    pmask_d  = bus_wdata;
    cmd_d    = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= '1;
      cmd_q   <= '0;
    end else begin
      if (pmask_en) pmask_q <= pmask_d;
      if (cmd_en)   cmd_q   <= cmd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (mask_rd) begin
      unique case (tgt)
        TGT_MASK: bus_rdata = pmask_q;
        TGT_CMD:  bus_rdata = cmd_q;
        TGT_XREG: bus_rdata = x_rdata;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ramdac_port_chk.sv
module ramdac_port_chk
  import ramdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              port_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] pmask_q,
  input logic [DATA_W-1:0] cmd_q,
  input seq_e              seq_mode,
  input logic [IDX_W-1:0]  index
);
  logic first_pend;
  logic m_rd, m_wr, m_acc;

  assign m_rd  = bus_rd && !bus_wr && port_sel;
  assign m_wr  = bus_wr && port_sel;
  assign m_acc = m_rd || m_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_pend <= 1'b0;
    else if (bus_wr && !port_sel) first_pend <= 1'b1;
    else if (m_acc) first_pend <= 1'b0;
  end

  AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && first_pend) |-> (bus_rdata == pmask_q)); // R2

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !m_wr |=> $stable(cmd_q)); // R3

  AST_XEN_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode != SEQ_PLAIN) |-> cmd_q[XEN_BIT]); // R5

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == SEQ_XDATA && m_acc) |=> (index == IDX_W'($past(index) + 1'b1))); // R6

  AST_MASK_HOLD_XDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode == SEQ_XDATA && m_wr) |=> $stable(pmask_q)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rd |-> (bus_rdata == '0)); // R11
endmodule

bind ramdac_port ramdac_port_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_sel  (port_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pmask_q   (pmask_q),
  .cmd_q     (cmd_q),
  .seq_mode  (seq_mode),
  .index     (index)
);

// File: tb/test_ramdac_port.sv
`timescale 1ns/1ps
module test_ramdac_port;
  logic       clk;
  logic       rst_n;
  logic       port_sel;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  int         n_chk;
  int         n_fail;
  bit         done;
  logic [7:0] q;

  ramdac_port i_ramdac_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic sel, input logic wr, input logic rd,
                     input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    port_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    #1 r = bus_rdata;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wa(input logic [7:0] d);
    logic [7:0] r;
    acc(1'b0, 1'b1, 1'b0, d, r);
  endtask
  task automatic wm(input logic [7:0] d);
    logic [7:0] r;
    acc(1'b1, 1'b1, 1'b0, d, r);
  endtask
  task automatic rm(output logic [7:0] r);
    acc(1'b1, 1'b0, 1'b1, 8'h00, r);
  endtask
  task automatic ra(output logic [7:0] r);
    acc(1'b0, 1'b0, 1'b1, 8'h00, r);
  endtask

  task automatic reads(input int n);
    logic [7:0] r;
    for (int i = 0; i < n; i++) rm(r);
  endtask

  task automatic set_cmd(input logic [7:0] v);
    wa(8'h00); reads(4); wm(v);
  endtask
  task automatic get_cmd(output logic [7:0] v);
    wa(8'h00); reads(4); rm(v);
  endtask
  task automatic get_mask(output logic [7:0] v);
    wa(8'h00); rm(v);
  endtask
  task automatic open_idx(input logic [15:0] idx);
    wa(8'h00); reads(5); wm(idx[7:0]); wm(idx[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    #1 chk("R11 idle rdata", bus_rdata, 8'h00);
    get_mask(r); chk("R1 mask reset", r, 8'hFF);
    get_cmd(r);  chk("R1 cmd reset", r, 8'h00);
    set_cmd(8'h14);
    open_idx(16'h0003);
    rm(r); chk("R1 pmode reset", r, 8'h00);
    rm(r); chk("R1 smode reset", r, 8'h00);
    rm(r); chk("R1 timing reset", r, 8'h00);
    open_idx(16'h0024);
    rm(r); chk("R1 clk lo reset", r, 8'h00);
    rm(r); chk("R1 clk hi reset", r, 8'h00);
    set_cmd(8'h00);
  endtask

  task automatic t_cmd;
    logic [7:0] r;
    wa(8'h00);
    rm(r); chk("R2 first read mask", r, 8'hFF);
    reads(3);
    rm(r); chk("R3 fifth read cmd", r, 8'h00);
    set_cmd(8'h4A);
    get_cmd(r); chk("R3 cmd write/read", r, 8'h4A);
    get_mask(r); chk("R3 mask untouched", r, 8'hFF);
  endtask

  task automatic t_sat;
    logic [7:0] r;
    wa(8'h00);
    reads(4);
    rm(r); chk("R4 read5 cmd", r, 8'h4A);
    rm(r); chk("R4 read6 mask", r, 8'hFF);
    rm(r); chk("R4 read7 mask", r, 8'hFF);
    rm(r); chk("R4 read8 mask", r, 8'hFF);
    wm(8'h3C);
    get_mask(r); chk("R4 late write to mask", r, 8'h3C);
    get_cmd(r);  chk("R4 cmd kept", r, 8'h4A);
  endtask

  task automatic t_disabled;
    logic [7:0] r;
    wa(8'h00); reads(5); wm(8'h11); wm(8'h22);
    get_mask(r); chk("R9 writes hit mask", r, 8'h22);
    get_cmd(r);  chk("R9 cmd kept", r, 8'h4A);
  endtask

  task automatic t_index;
    logic [7:0] r;
    set_cmd(8'h14);
    open_idx(16'h0003); wm(8'h05); wm(8'h06); wm(8'h02);
    open_idx(16'h0024); wm(8'h34); wm(8'h12);
    open_idx(16'h0006); wm(8'hAA);
    open_idx(16'h0103); wm(8'h77);
    open_idx(16'h0003);
    rm(r); chk("R7 pmode", r, 8'h05);
    rm(r); chk("R6 step smode", r, 8'h06);
    rm(r); chk("R6 step timing", r, 8'h02);
    rm(r); chk("R7 unused 0x0006", r, 8'h00);
    open_idx(16'h0024);
    rm(r); chk("R7 clk lo", r, 8'h34);
    rm(r); chk("R7 clk hi", r, 8'h12);
    open_idx(16'hFFFF);
    rm(r); chk("R6 0xFFFF", r, 8'h00);
    reads(3);
    rm(r); chk("R6 wrap to 0x0003", r, 8'h05);
    get_mask(r); chk("R6 mask untouched", r, 8'h22);
  endtask

  task automatic t_exit;
    logic [7:0] r;
    open_idx(16'h0004); wm(8'h66);
    wa(8'h00);
    rm(r); chk("R8 mask after exit", r, 8'h22);
    wm(8'h99);
    get_mask(r); chk("R8 write reaches mask", r, 8'h99);
    open_idx(16'h0003);
    rm(r); chk("R8 pmode kept", r, 8'h05);
    rm(r); chk("R8 smode new", r, 8'h66);
  endtask

  task automatic t_clear;
    logic [7:0] r;
    wa(8'h00); reads(3); wm(8'hFF);
    reads(3);
    rm(r); chk("R10 fourth read mask", r, 8'hFF);
    rm(r); chk("R10 recount to cmd", r, 8'h14);
    wa(8'h00); reads(2);
    ra(r); chk("R11 addr read zero", r, 8'h00);
    reads(2);
    rm(r); chk("R11 count not disturbed", r, 8'h14);
  endtask

  task automatic t_both;
    logic [7:0] r;
    wa(8'h00);
    acc(1'b1, 1'b1, 1'b1, 8'h5C, r);
    chk("R12 no read data", r, 8'h00);
    get_mask(r); chk("R12 write taken", r, 8'h5C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    port_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_cmd();
    t_sat();
    t_disabled();
    t_index();
    t_exit();
    t_clear();
    t_both();
    ra(q);
    finish_run();
  end
endmodule